// File: doc/BRIEF.md
# Serial CRC-8 Trailer Generator

This block sits beside the serial transmit path of a single-wire device and builds an 8-bit check value over read data while that data leaves the device one bit at a time, least significant bit of each byte first. A start pulse carries the transaction opcode. Only the opcode that selects a checked read (binary 10) arms the generator. Every other opcode, writes included, leaves it idle, and the transmit path then runs without a trailer.

While the block is armed, each transmitted bit that is marked valid is folded into an 8-stage shift register. The register is cleared at arming, and its feedback realises the generator polynomial x^8 + x^5 + x^4 + 1 in reflected form, that is, a right shift with mask 0x8C. When the transmit path signals that the data has ended, the register contents become the check byte. The block shifts that byte out on its own serial output, low bit first, with a valid strobe, and then raises a one-cycle completion flag. The register does not accumulate while the trailer is going out.

Top module: `crc8_trailer`

## Requirements
- R1: After reset, `crc_vld_o`, `crc_bit_o` and `crc_done_o` are all 0. `crc_bit_o` is 0 in every cycle in which `crc_vld_o` is 0.
- R2: A `start_i` pulse accepted while the block is idle arms it and clears the register to 0x00 only when `opcode_i` equals 2'b10. With opcodes 2'b00, 2'b01 or 2'b11 the block stays idle, and no `crc_vld_o` or `crc_done_o` follows, even after `data_end_i`.
- R3: While the block is armed, each cycle with `tx_vld_i` high folds `tx_bit_i` into the register. The trailer then equals the byte-wise reflected CRC (zero initial value, per byte: crc ^= byte, then eight times shift right and XOR 0x8C when the dropped bit was 1) over the bytes sent LSB first. The nine ASCII bytes "123456789" give 0xA1.
- R4: `tx_vld_i` is ignored while the block is idle. Bits presented before the arming start pulse do not change the trailer.
- R5: The cycle after `data_end_i` is sampled while the block is armed, `crc_vld_o` goes high for exactly 8 consecutive cycles. `crc_bit_o` carries trailer bit 0 first and bit 7 last.
- R6: `crc_done_o` is high for exactly one cycle, the cycle after the eighth trailer bit, with `crc_vld_o` low. After that the block is idle.
- R7: A data bit whose `tx_vld_i` coincides with `data_end_i` is included in the trailer.
- R8: `data_end_i` right after arming, with no data bits, gives the trailer 0x00.
- R9: A `start_i` pulse while the block is armed is ignored and does not clear the register.
- R10: `tx_vld_i` and `tx_bit_i` activity while the trailer is being shifted out does not change the trailer bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transaction start pulse |
| opcode_i | input | OPC_W | Opcode qualifying `start_i` |
| tx_bit_i | input | 1 | Serial data bit being transmitted |
| tx_vld_i | input | 1 | `tx_bit_i` is transmitted this cycle |
| data_end_i | input | 1 | Last data bit has been sent; emit trailer |
| crc_bit_o | output | 1 | Serial trailer bit, LSB first |
| crc_vld_o | output | 1 | `crc_bit_o` is valid |
| crc_done_o | output | 1 | One-cycle pulse after the last trailer bit |

## Verification
The bench drives inputs on the falling edge. When `data_end_i` is driven at one falling edge, trailer bit i is due at falling edge i+1, because one register stage lies between the sampled end request and the valid strobe. The completion flag is due at falling edge 9, and the idle state at falling edge 10. The collection task samples exactly at those edges and compares the assembled byte against a byte-wise reference computed in the bench. The sweep covers every single-byte value, multi-byte frames, frames where the end request coincides with the last bit, empty frames, bypass opcodes, and noise on the data inputs before arming, during data and during emission.

// File: rtl/crc8_trailer_pkg.sv
package crc8_trailer_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ACCUM = 2'd1,
        SEQ_EMIT  = 2'd2,
        SEQ_DONE  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/crc8_trailer_lfsr.sv
module crc8_trailer_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] POLY = 8'h8C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         feed_i,
    input  logic         drain_i,
    input  logic         din_i,
    output logic [W-1:0] state_o,
    output logic         lsb_o
);

    typedef struct packed {
        logic [W-1:0] crc;
    } lfsr_t;

    lfsr_t lfsr_d, lfsr_q;

    logic         fb;
    logic [W-1:0] step_feed;
    logic [W-1:0] step_drain;

    assign fb = din_i ^ lfsr_q.crc[0];

    // Per-stage next value: shift right, feedback into the taps set in POLY.
    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == W - 1) begin : g_top
            assign step_feed[i]  = POLY[i] & fb;
            assign step_drain[i] = 1'b0;
        end else begin : g_mid
            assign step_feed[i]  = lfsr_q.crc[i+1] ^ (POLY[i] & fb);
            assign step_drain[i] = lfsr_q.crc[i+1];
        end
    end

    always_comb begin
        lfsr_d = lfsr_q;
        if (clr_i) begin
            lfsr_d.crc = '0;
        end else if (feed_i) begin
            lfsr_d.crc = step_feed;
        end else if (drain_i) begin
            lfsr_d.crc = step_drain;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= '0;
        end else begin
            lfsr_q <= lfsr_d;
        end
    end

    assign state_o = lfsr_q.crc;
    assign lsb_o   = lfsr_q.crc[0];

    // R2
    clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (state_o == '0));

    // R3
    single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_i, feed_i, drain_i}));

    // R3
    zero_stays_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_i && !din_i && state_o == '0) |=> (state_o == '0));

    // R5
    drain_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_i |=> (state_o[W-2:0] == $past(state_o[W-1:1]) && !state_o[W-1]));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !feed_i && !drain_i) |=> $stable(state_o));

endmodule

// File: rtl/crc8_trailer_seq.sv
module crc8_trailer_seq
    import crc8_trailer_pkg::*;
#(
    parameter int              W       = 8,
    parameter int              OPC_W   = 2,
    parameter logic [OPC_W-1:0] OPC_CRC = 2'b10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             tx_vld_i,
    input  logic             data_end_i,
    output logic             clr_o,
    output logic             feed_o,
    output logic             drain_o,
    output logic             crc_vld_o,
    output logic             done_o
);

    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic arm_req;

    assign arm_req = start_i && (opcode_i == OPC_CRC);

    always_comb begin
        seq_d   = seq_q;
        clr_o   = 1'b0;
        feed_o  = 1'b0;
        drain_o = 1'b0;
        unique case (seq_q.st)
            SEQ_IDLE, SEQ_DONE: begin
                seq_d.st = SEQ_IDLE;
                if (arm_req) begin
                    clr_o    = 1'b1;
                    seq_d.st = SEQ_ACCUM;
                end
            end
            SEQ_ACCUM: begin
                feed_o = tx_vld_i;
                if (data_end_i) begin
                    seq_d.st  = SEQ_EMIT;
                    seq_d.cnt = '0;
                end
            end
            SEQ_EMIT: begin
                drain_o   = 1'b1;
                seq_d.cnt = seq_q.cnt + 1'b1;
                if (seq_q.cnt == CNT_LAST) begin
                    seq_d.st  = SEQ_DONE;
                    seq_d.cnt = '0;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign crc_vld_o = (seq_q.st == SEQ_EMIT);
    assign done_o    = (seq_q.st == SEQ_DONE);

    // R2
    bypass_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SEQ_IDLE && !arm_req) |=> (seq_q.st == SEQ_IDLE));

    // R5
    emit_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_vld_o) |-> ($past(data_end_i) && $past(seq_q.st) == SEQ_ACCUM));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_after_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(crc_vld_o) && !crc_vld_o));

    // R5
    emit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_vld_o && seq_q.cnt != CNT_LAST) |=> crc_vld_o);

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SEQ_ACCUM) |-> !clr_o);

endmodule

// File: rtl/crc8_trailer.sv
module crc8_trailer #(
    parameter int   W       = 8,
    parameter int   OPC_W   = 2,
    parameter logic [OPC_W-1:0] OPC_CRC = 2'b10,
    parameter logic [W-1:0]     POLY    = 8'h8C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             tx_bit_i,
    input  logic             tx_vld_i,
    input  logic             data_end_i,
    output logic             crc_bit_o,
    output logic             crc_vld_o,
    output logic             crc_done_o
);

    logic         clr, feed, drain, lsb;
    logic [W-1:0] state;

    crc8_trailer_seq #(
        .W       (W),
        .OPC_W   (OPC_W),
        .OPC_CRC (OPC_CRC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .opcode_i   (opcode_i),
        .tx_vld_i   (tx_vld_i),
        .data_end_i (data_end_i),
        .clr_o      (clr),
        .feed_o     (feed),
        .drain_o    (drain),
        .crc_vld_o  (crc_vld_o),
        .done_o     (crc_done_o)
    );

    crc8_trailer_lfsr #(
        .W    (W),
        .POLY (POLY)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .feed_i  (feed),
        .drain_i (drain),
        .din_i   (tx_bit_i),
        .state_o (state),
        .lsb_o   (lsb)
    );

    assign crc_bit_o = crc_vld_o & lsb;

    // R1
    quiet_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_vld_o |-> !crc_bit_o);

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_vld_o && crc_done_o));

endmodule

// File: tb/crc8_trailer_tb.sv
module crc8_trailer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] opcode_i = 2'b00;
    logic       tx_bit_i = 1'b0;
    logic       tx_vld_i = 1'b0;
    logic       data_end_i = 1'b0;
    logic       crc_bit_o, crc_vld_o, crc_done_o;

    int nvec = 0;
    int nfail = 0;
    logic [7:0] data_buf [16];
    logic [31:0] lcg = 32'h1234_5678;

    always #10 clk = ~clk;

    crc8_trailer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .opcode_i   (opcode_i),
        .tx_bit_i   (tx_bit_i),
        .tx_vld_i   (tx_vld_i),
        .data_end_i (data_end_i),
        .crc_bit_o  (crc_bit_o),
        .crc_vld_o  (crc_vld_o),
        .crc_done_o (crc_done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input int n);
        logic [7:0] c = 8'h00;
        for (int k = 0; k < n; k++) begin
            c = c ^ data_buf[k];
            for (int b = 0; b < 8; b++) begin
                c = c[0] ? ((c >> 1) ^ 8'h8C) : (c >> 1);
            end
        end
        return c;
    endfunction

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // Noise on the data inputs while idle (R4).
    task automatic idle_noise(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            tx_vld_i = 1'b1;
            tx_bit_i = next_rand() >> 7;
        end
        @(negedge clk);
        tx_vld_i = 1'b0;
    endtask

    // Leaves the bench at the falling edge where data_end_i is driven high.
    task automatic send_frame(input int n, input logic [1:0] opc,
                              input bit end_with_last, input int restart_at);
        @(negedge clk);
        start_i  = 1'b1;
        opcode_i = opc;
        for (int idx = 0; idx < n * 8; idx++) begin
            @(negedge clk);
            start_i  = (idx == restart_at);
            tx_vld_i = 1'b1;
            tx_bit_i = data_buf[idx / 8][idx % 8];
            if (end_with_last && idx == n * 8 - 1) data_end_i = 1'b1;
        end
        if (!(end_with_last && n > 0)) begin
            @(negedge clk);
            start_i    = 1'b0;
            tx_vld_i   = 1'b0;
            data_end_i = 1'b1;
        end
    endtask

    // Trailer bit i due at falling edge i+1, done at edge 9, idle at edge 10.
    task automatic collect(input logic [7:0] exp, input string req, input bit noise);
        logic [7:0] got = 8'h00;
        bit vld_ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            data_end_i = 1'b0;
            start_i    = 1'b0;
            tx_vld_i   = noise ? i[0] : 1'b0;
            tx_bit_i   = noise ? ~i[1] : 1'b0;
            if (!crc_vld_o || crc_done_o) vld_ok = 1'b0;
            got[i] = crc_bit_o;
        end
        @(negedge clk);
        tx_vld_i = 1'b0;
        check(vld_ok, "R5", "valid strobe for 8 cycles", {31'd0, vld_ok}, 32'd1);
        check(crc_done_o && !crc_vld_o, "R6", "done after 8th bit",
              {30'd0, crc_done_o, crc_vld_o}, 32'h2);
        @(negedge clk);
        check(!crc_done_o && !crc_vld_o, "R6", "done one cycle",
              {30'd0, crc_done_o, crc_vld_o}, 32'h0);
        check(got == exp, req, "trailer byte", {24'd0, got}, {24'd0, exp});
    endtask

    task automatic bypass_frame(input logic [1:0] opc);
        bit quiet = 1'b1;
        data_buf[0] = 8'hA5;
        send_frame(1, opc, 1'b0, -1);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            data_end_i = 1'b0;
            if (crc_vld_o || crc_done_o || crc_bit_o) quiet = 1'b0;
        end
        check(quiet, "R2", "bypass opcode produces no trailer", {31'd0, quiet}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!crc_vld_o && !crc_bit_o && !crc_done_o, "R1", "outputs in reset",
              {29'd0, crc_vld_o, crc_bit_o, crc_done_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!crc_vld_o && !crc_bit_o && !crc_done_o, "R1", "outputs after reset",
              {29'd0, crc_vld_o, crc_bit_o, crc_done_o}, 32'd0);

        // R3: known check string
        for (int k = 0; k < 9; k++) data_buf[k] = 8'(8'h31 + k);
        send_frame(9, 2'b10, 1'b0, -1);
        collect(8'hA1, "R3", 1'b0);

        // R3 R7 R10: every single byte value
        for (int v = 0; v < 256; v++) begin
            data_buf[0] = 8'(v);
            send_frame(1, 2'b10, v[0], -1);
            collect(ref_crc(1), v[0] ? "R7" : "R3", v[1]);
        end

        // R8: empty frame
        send_frame(0, 2'b10, 1'b0, -1);
        collect(8'h00, "R8", 1'b0);

        // R2: bypass opcodes, then a normal frame still works
        bypass_frame(2'b00);
        bypass_frame(2'b01);
        bypass_frame(2'b11);

        // R4 R9: multi-byte frames with idle noise and a start while armed
        for (int f = 0; f < 40; f++) begin
            int n;
            n = 1 + (f % 9);
            for (int k = 0; k < n; k++) data_buf[k] = 8'(next_rand() >> 13);
            if (f % 3 == 0) idle_noise(8);
            send_frame(n, 2'b10, f[1], (f % 2 == 1) ? (f % (n * 8)) : -1);
            collect(ref_crc(n), (f % 3 == 0) ? "R4" : ((f % 2 == 1) ? "R9" : "R3"), f[2]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule